// File: doc/BRIEF.md
# Cache Slice Attribute Register File

This block keeps, for every partition ("slice") of a shared last-level cache, two 32-bit configuration words. The first word holds the slice's private way mask and its shared way mask. The second word holds the cache mode, a flag that limits lookups, a fixed-size flag, a replacement priority and a per-bank capacity in lines. Software reaches the words through a register request/response port. The cache allocator reads the decoded fields of every slice on plain output buses.

For one slice, picked by a select input, the block also works out two masks. The lookup mask gives the ways a hit search has to examine. The allocation mask gives the ways that slice may fill. A slice always owns its private ways. It may also borrow its shared ways, but only those that no other currently active slice claims as private. The set of active slices is an input vector.

The request channel uses valid/ready. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. A read produces one response beat on a valid/ready response channel. While a response waits with `rsp_ready_i` low, `req_ready_o` is held low, so no new request is taken and the pending data cannot be overtaken. A write produces no response.

Top module: `slice_attr_regfile`

## Requirements
- R1: After reset every stored word is 0, `rsp_valid_o` is 0, `req_ready_o` is 1, the lookup mask is 0xFFF and the allocation mask is 0.
- R2: The first word of slice n is at byte address 0x21000 + 8n and the second word at 0x21004 + 8n. A read returns the last value written, with undefined bits reading 0. In the first word only bits [11:0] and [27:16] exist. In the second word only bits [6:0] and [31:16] exist. Writes to undefined bits are dropped.
- R3: Each slice's decoded outputs carry its stored fields. First word: private ways = bits [11:0], shared ways = bits [27:16]. Second word: mode = bits [1:0], lookup-limit flag = bit 2, fixed-size flag = bit 3, priority = bits [6:4], capacity in lines = bits [31:16].
- R4: For the selected slice, the lookup mask is private OR shared ways when its lookup-limit flag is 1, and all 12 ways when the flag is 0.
- R5: For the selected slice s, the allocation mask equals private[s] OR (shared[s] AND NOT the OR of private[t] over every active slice t other than s). The activity of s itself does not matter.
- R6: An address below 0x21000, at or above 0x21000 + 8·NUM_SLICES, or not 4-byte aligned maps to nothing. A write there changes no stored word. A read there still returns one response, with data 0.
- R7: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, `req_ready_o` is 0 and `rsp_rdata_o` holds its value.
- R8: A read taken on an edge gives `rsp_valid_o` = 1 from that edge on. A write taken on an edge is visible on the decoded and mask outputs right after that edge, and it produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Register request present |
| req_ready_o | output | 1 | Request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (20) | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data present |
| rsp_ready_i | input | 1 | Read data consumed |
| rsp_rdata_o | output | 32 | Read data |
| active_i | input | NUM_SLICES (8) | Active-slice vector, bit per slice |
| sel_i | input | SEL_W (3) | Slice whose masks are computed |
| probe_mask_o | output | 12 | Lookup way mask of selected slice |
| alloc_mask_o | output | 12 | Allocation way mask of selected slice |
| res_ways_o | output | NUM_SLICES*12 | Private way masks, slice n at [12n +: 12] |
| bonus_ways_o | output | NUM_SLICES*12 | Shared way masks, slice n at [12n +: 12] |
| mode_o | output | NUM_SLICES*2 | Cache mode, 0 normal, nonzero tightly-coupled |
| probe_tgt_o | output | NUM_SLICES | Lookup-limit flags |
| fixed_size_o | output | NUM_SLICES | Fixed-size flags |
| prio_o | output | NUM_SLICES*3 | Priorities, slice n at [3n +: 3] |
| cap_lines_o | output | NUM_SLICES*16 | Capacity per bank in lines, slice n at [16n +: 16] |

## Verification
Read-back and register update can meet in one cycle. A read is taken with `rsp_ready_i` held low, and then a write to that same word is presented at once. The bench checks three things over several cycles: the write stays blocked, the held read data keeps the old word, and the decoded outputs do not move. After the response is released, the read must still return the old value, and the write must land on the edge that follows. The mask logic is judged across several active-slice patterns for every select value, against a model built from the written words.

// File: rtl/slattr_pkg.sv
package slattr_pkg;
  localparam int WAYS      = 12;
  localparam int MODE_W    = 2;
  localparam int PRIO_W    = 3;
  localparam int CAP_W     = 16;
  // first word layout
  localparam int W0_RES_LSB   = 0;
  localparam int W0_BONUS_LSB = 16;
  // second word layout
  localparam int W1_MODE_LSB  = 0;
  localparam int W1_PTGT_BIT  = 2;
  localparam int W1_FIXED_BIT = 3;
  localparam int W1_PRIO_LSB  = 4;
  localparam int W1_CAP_LSB   = 16;
  localparam logic [31:0] W0_KEEP = 32'h0FFF_0FFF;
  localparam logic [31:0] W1_KEEP = 32'hFFFF_007F;

  typedef struct packed {
    logic [CAP_W-1:0]  cap;
    logic [PRIO_W-1:0] prio;
    logic              fixed;
    logic              ptgt;
    logic [MODE_W-1:0] mode;
  } attr_t;

  function automatic attr_t unpack_w1(input logic [31:0] w);
    attr_t a;
    a.cap   = w[W1_CAP_LSB +: CAP_W];
    a.prio  = w[W1_PRIO_LSB +: PRIO_W];
    a.fixed = w[W1_FIXED_BIT];
    a.ptgt  = w[W1_PTGT_BIT];
    a.mode  = w[W1_MODE_LSB +: MODE_W];
    return a;
  endfunction
endpackage

// File: rtl/slattr_store.sv
module slattr_store #(
  parameter int NUM_SLICES = 8,
  parameter int SEL_W      = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [SEL_W-1:0]             wr_slice_i,
  input  logic                         wr_word_i,
  input  logic [31:0]                  wr_data_i,
  output logic [NUM_SLICES-1:0][31:0]  w0_o,
  output logic [NUM_SLICES-1:0][31:0]  w1_o
);
  import slattr_pkg::*;

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    logic hit;
    assign hit = wr_en_i && (wr_slice_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        w0_o[g] <= '0;
        w1_o[g] <= '0;
      end else if (hit) begin
        if (wr_word_i) w1_o[g] <= wr_data_i & W1_KEEP;
        else           w0_o[g] <= wr_data_i & W0_KEEP;
      end
    end
  end
endmodule

// File: rtl/slattr_masks.sv
module slattr_masks #(
  parameter int NUM_SLICES = 8,
  parameter int SEL_W      = 3
) (
  input  logic [NUM_SLICES-1:0][slattr_pkg::WAYS-1:0] res_i,
  input  logic [NUM_SLICES-1:0][slattr_pkg::WAYS-1:0] bonus_i,
  input  logic [NUM_SLICES-1:0]                       ptgt_i,
  input  logic [NUM_SLICES-1:0]                       active_i,
  input  logic [SEL_W-1:0]                            sel_i,
  output logic [slattr_pkg::WAYS-1:0]                 probe_o,
  output logic [slattr_pkg::WAYS-1:0]                 alloc_o
);
  import slattr_pkg::*;

  logic [WAYS-1:0] own_res, own_bonus, foreign_res;
  logic            own_ptgt;

  always_comb begin
    own_res     = '0;
    own_bonus   = '0;
    own_ptgt    = 1'b0;
    foreign_res = '0;
    for (int t = 0; t < NUM_SLICES; t++) begin
      if (sel_i == SEL_W'(t)) begin
        own_res   = res_i[t];
        own_bonus = bonus_i[t];
        own_ptgt  = ptgt_i[t];
      end else if (active_i[t]) begin
        foreign_res = foreign_res | res_i[t];
      end
    end
  end

  assign alloc_o = own_res | (own_bonus & ~foreign_res);
  assign probe_o = own_ptgt ? (own_res | own_bonus) : {WAYS{1'b1}};
endmodule

// File: rtl/slice_attr_regfile.sv
module slice_attr_regfile #(
  parameter int                NUM_SLICES = 8,
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 20'h21000,
  localparam int               SEL_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int               WAYS       = slattr_pkg::WAYS
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic                          req_write_i,
  input  logic [ADDR_W-1:0]             req_addr_i,
  input  logic [31:0]                   req_wdata_i,
  output logic                          rsp_valid_o,
  input  logic                          rsp_ready_i,
  output logic [31:0]                   rsp_rdata_o,
  input  logic [NUM_SLICES-1:0]         active_i,
  input  logic [SEL_W-1:0]              sel_i,
  output logic [WAYS-1:0]               probe_mask_o,
  output logic [WAYS-1:0]               alloc_mask_o,
  output logic [NUM_SLICES*WAYS-1:0]    res_ways_o,
  output logic [NUM_SLICES*WAYS-1:0]    bonus_ways_o,
  output logic [NUM_SLICES*2-1:0]       mode_o,
  output logic [NUM_SLICES-1:0]         probe_tgt_o,
  output logic [NUM_SLICES-1:0]         fixed_size_o,
  output logic [NUM_SLICES*3-1:0]       prio_o,
  output logic [NUM_SLICES*16-1:0]      cap_lines_o
);
  import slattr_pkg::*;

  localparam int SPAN = NUM_SLICES * 8;

  // address decode
  logic [ADDR_W-1:0] off;
  logic              hit, word_sel, accept;
  logic [SEL_W-1:0]  idx;

  assign off      = req_addr_i - BASE_ADDR;
  assign hit      = (req_addr_i >= BASE_ADDR) && (off < ADDR_W'(SPAN)) && (off[1:0] == 2'b00);
  assign word_sel = off[2];
  assign idx      = off[3 +: SEL_W];
  assign accept   = req_valid_i && req_ready_o;

  // storage
  logic [NUM_SLICES-1:0][31:0] w0, w1;

  slattr_store #(.NUM_SLICES(NUM_SLICES), .SEL_W(SEL_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (accept && req_write_i && hit),
    .wr_slice_i (idx),
    .wr_word_i  (word_sel),
    .wr_data_i  (req_wdata_i),
    .w0_o       (w0),
    .w1_o       (w1)
  );

  // read path with one response slot
  logic [31:0] rd_mux, rsp_q;
  logic        rsp_v_q;

  assign rd_mux      = !hit ? 32'h0 : (word_sel ? w1[idx] : w0[idx]);
  assign req_ready_o = !rsp_v_q || rsp_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else if (accept && !req_write_i) begin
      rsp_v_q <= 1'b1;
      rsp_q   <= rd_mux;
    end else if (rsp_ready_i) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_v_q;
  assign rsp_rdata_o = rsp_q;

  // decode per slice
  logic [NUM_SLICES-1:0][WAYS-1:0] res_a, bonus_a;
  logic [NUM_SLICES-1:0]           ptgt_a;

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_dec
    attr_t a;
    assign a       = unpack_w1(w1[g]);
    assign res_a[g]   = w0[g][W0_RES_LSB +: WAYS];
    assign bonus_a[g] = w0[g][W0_BONUS_LSB +: WAYS];
    assign ptgt_a[g]  = a.ptgt;
    assign res_ways_o[g*WAYS +: WAYS]     = res_a[g];
    assign bonus_ways_o[g*WAYS +: WAYS]   = bonus_a[g];
    assign mode_o[g*MODE_W +: MODE_W]     = a.mode;
    assign probe_tgt_o[g]                 = a.ptgt;
    assign fixed_size_o[g]                = a.fixed;
    assign prio_o[g*PRIO_W +: PRIO_W]     = a.prio;
    assign cap_lines_o[g*CAP_W +: CAP_W]  = a.cap;
  end

  slattr_masks #(.NUM_SLICES(NUM_SLICES), .SEL_W(SEL_W)) u_masks (
    .res_i    (res_a),
    .bonus_i  (bonus_a),
    .ptgt_i   (ptgt_a),
    .active_i (active_i),
    .sel_i    (sel_i),
    .probe_o  (probe_mask_o),
    .alloc_o  (alloc_mask_o)
  );
endmodule

// File: rtl/slattr_checker.sv
module slattr_checker #(
  parameter int NUM_SLICES = 8,
  parameter int SEL_W      = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_valid_i,
  input logic                       req_ready_o,
  input logic                       req_write_i,
  input logic                       rsp_valid_o,
  input logic                       rsp_ready_i,
  input logic [31:0]                rsp_rdata_o,
  input logic [SEL_W-1:0]           sel_i,
  input logic [11:0]                probe_mask_o,
  input logic [11:0]                alloc_mask_o,
  input logic [NUM_SLICES*12-1:0]   res_ways_o,
  input logic [NUM_SLICES*12-1:0]   bonus_ways_o,
  input logic [NUM_SLICES-1:0]      probe_tgt_o
);
  logic [11:0] s_res, s_bonus;
  logic        s_ptgt;

  always_comb begin
    s_res = '0; s_bonus = '0; s_ptgt = 1'b0;
    for (int t = 0; t < NUM_SLICES; t++) begin
      if (sel_i == SEL_W'(t)) begin
        s_res   = res_ways_o[t*12 +: 12];
        s_bonus = bonus_ways_o[t*12 +: 12];
        s_ptgt  = probe_tgt_o[t];
      end
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o)); // R7
  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o); // R7
  AST_READ_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !req_write_i |=> rsp_valid_o); // R8
  AST_WRITE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_write_i |=> !rsp_valid_o); // R8
  AST_ALLOC_KEEPS_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_mask_o & s_res) == s_res); // R5
  AST_ALLOC_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_mask_o & ~(s_res | s_bonus)) == 12'h0); // R5
  AST_PROBE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_ptgt |-> probe_mask_o == 12'hFFF); // R4
  AST_PROBE_LIMITED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ptgt |-> probe_mask_o == (s_res | s_bonus)); // R4
endmodule

bind slice_attr_regfile slattr_checker #(.NUM_SLICES(NUM_SLICES), .SEL_W(SEL_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_write_i  (req_write_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_rdata_o  (rsp_rdata_o),
  .sel_i        (sel_i),
  .probe_mask_o (probe_mask_o),
  .alloc_mask_o (alloc_mask_o),
  .res_ways_o   (res_ways_o),
  .bonus_ways_o (bonus_ways_o),
  .probe_tgt_o  (probe_tgt_o)
);

// File: tb/slice_attr_regfile_tb_top.sv
module slice_attr_regfile_tb_top;
  localparam int          NS   = 8;
  localparam int          AW   = 20;
  localparam logic [19:0] BASE = 20'h21000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0]  req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic [NS-1:0]  active = '0;
  logic [2:0]     sel = '0;
  logic           req_ready, rsp_valid;
  logic [31:0]    rsp_rdata;
  logic [11:0]    probe_mask, alloc_mask;
  logic [NS*12-1:0] res_ways, bonus_ways;
  logic [NS*2-1:0]  mode;
  logic [NS-1:0]    ptgt, fixed;
  logic [NS*3-1:0]  prio;
  logic [NS*16-1:0] cap;

  slice_attr_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .active_i(active), .sel_i(sel),
    .probe_mask_o(probe_mask), .alloc_mask_o(alloc_mask),
    .res_ways_o(res_ways), .bonus_ways_o(bonus_ways), .mode_o(mode),
    .probe_tgt_o(ptgt), .fixed_size_o(fixed), .prio_o(prio), .cap_lines_o(cap)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_w0[NS], m_w1[NS];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [AW-1:0] a);
    return (a >= BASE) && (a < BASE + AW'(NS*8)) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] model_rd(input logic [AW-1:0] a);
    int i;
    if (!mapped(a)) return 32'h0;
    i = int'((a - BASE) >> 3);
    return a[2] ? m_w1[i] : m_w0[i];
  endfunction

  function automatic logic [11:0] exp_alloc(input int s, input logic [NS-1:0] act);
    logic [11:0] oth = '0;
    for (int t = 0; t < NS; t++) if (t != s && act[t]) oth |= m_w0[t][11:0];
    return m_w0[s][11:0] | (m_w0[s][27:16] & ~oth);
  endfunction

  function automatic logic [11:0] exp_probe(input int s);
    return m_w1[s][2] ? (m_w0[s][11:0] | m_w0[s][27:16]) : 12'hFFF;
  endfunction

  // monitor: pops expected read data on each response beat
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 unexpected response actual=%0h expected=none", rsp_rdata);
      end else begin
        chk(tag_q.pop_front(), {32'h0, rsp_rdata}, {32'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic drive(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
  endtask

  task automatic wait_accept();
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    drive(1'b1, a, d);
    wait_accept();
    if (mapped(a)) begin
      if (a[2]) m_w1[int'((a - BASE) >> 3)] = d & 32'hFFFF_007F;
      else      m_w0[int'((a - BASE) >> 3)] = d & 32'h0FFF_0FFF;
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    exp_q.push_back(model_rd(a));
    tag_q.push_back(tag);
    drive(1'b0, a, 32'h0);
    wait_accept();
  endtask

  function automatic logic [AW-1:0] ad(input int s, input int w);
    return BASE + AW'(s * 8 + w * 4);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    logic [NS-1:0] pats[4];
    for (int s = 0; s < NS; s++) begin m_w0[s] = '0; m_w1[s] = '0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 probe", {52'h0, probe_mask}, 64'hFFF);
    chk("R1 alloc", {52'h0, alloc_mask}, 64'h0);
    chk("R1 ready", {63'h0, req_ready}, 64'h1);
    chk("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
    @(posedge clk); #2;
    rd(ad(0, 0), "R1 word0 s0");
    rd(ad(7, 1), "R1 word1 s7");

    // R2 masking of undefined bits, R8 write timing
    wr(ad(0, 0), 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 write visible next", {52'h0, res_ways[11:0]}, 64'hFFF);
    @(posedge clk); #2;
    wr(ad(0, 1), 32'hFFFF_FFFF);
    rd(ad(0, 0), "R2 word0 masked");
    rd(ad(0, 1), "R2 word1 masked");
    @(negedge clk);
    // R3 all-ones field decode
    chk("R3 mode", {62'h0, mode[1:0]}, 64'h3);
    chk("R3 prio", {61'h0, prio[2:0]}, 64'h7);
    chk("R3 cap", {48'h0, cap[15:0]}, 64'hFFFF);
    chk("R3 flags", {62'h0, fixed[0], ptgt[0]}, 64'h3);
    @(posedge clk); #2;

    // realistic programming
    wr(ad(0, 0), 32'h0); wr(ad(0, 1), 32'h0);
    wr(ad(1, 0), 32'h0FFC_0002); wr(ad(1, 1), 32'h5800_0014);
    wr(ad(2, 0), 32'h0000_00F0); wr(ad(2, 1), 32'h1000_0028);
    wr(ad(3, 0), 32'h00FC_0F00); wr(ad(3, 1), 32'h0800_0024);
    wr(ad(5, 0), 32'hF001_F00E); wr(ad(5, 1), 32'h0123_0F5A);
    for (int s = 0; s < NS; s++) rd(ad(s, 0), "R2 readback word0");
    rd(ad(5, 1), "R2 readback word1");

    // R6 unmapped accesses
    wr(BASE - 20'd4, 32'hFFFF_FFFF);
    wr(BASE + 20'(NS * 8), 32'hFFFF_FFFF);
    wr(ad(2, 0) + 20'd1, 32'h0FFF_0FFF);
    wr(20'h00000, 32'hFFFF_FFFF);
    rd(BASE - 20'd4, "R6 read below");
    rd(BASE + 20'(NS * 8), "R6 read above");
    rd(ad(2, 0) + 20'd2, "R6 read misaligned");
    rd(ad(2, 0), "R6 slice2 untouched");
    rd(ad(7, 0), "R6 slice7 untouched");
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      chk("R3 res", {52'h0, res_ways[s*12 +: 12]}, {52'h0, m_w0[s][11:0]});
      chk("R3 bonus", {52'h0, bonus_ways[s*12 +: 12]}, {52'h0, m_w0[s][27:16]});
      chk("R3 mode", {62'h0, mode[s*2 +: 2]}, {62'h0, m_w1[s][1:0]});
      chk("R3 ptgt fixed", {62'h0, fixed[s], ptgt[s]}, {62'h0, m_w1[s][3:2]});
      chk("R3 prio", {61'h0, prio[s*3 +: 3]}, {61'h0, m_w1[s][6:4]});
      chk("R3 cap", {48'h0, cap[s*16 +: 16]}, {48'h0, m_w1[s][31:16]});
    end

    // R4 and R5 across active patterns
    pats[0] = 8'h00; pats[1] = 8'h0E; pats[2] = 8'h02; pats[3] = 8'hFF;
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < NS; s++) begin
        @(posedge clk); #2;
        active = pats[p]; sel = 3'(s);
        @(negedge clk);
        chk("R5 alloc", {52'h0, alloc_mask}, {52'h0, exp_alloc(s, pats[p])});
        chk("R4 probe", {52'h0, probe_mask}, {52'h0, exp_probe(s)});
      end
    end
    // hand-worked corner: slice1 with slices 1..3 active
    @(posedge clk); #2; active = 8'h0E; sel = 3'd1;
    @(negedge clk);
    chk("R5 shared ways blocked by others", {52'h0, alloc_mask}, 64'h00E);
    chk("R4 limited lookup", {52'h0, probe_mask}, 64'hFFE);

    // R7 read held under back-pressure while a write to the same word waits
    @(posedge clk); #2;
    rsp_ready = 1'b0;
    rd(ad(1, 0), "R7 held read old value");
    drive(1'b1, ad(1, 0), 32'h0FF8_0003);
    @(negedge clk);
    chk("R8 response after read", {63'h0, rsp_valid}, 64'h1);
    held = rsp_rdata;
    for (int k = 0; k < 3; k++) begin
      chk("R7 ready low", {63'h0, req_ready}, 64'h0);
      chk("R7 data held", {32'h0, rsp_rdata}, {32'h0, held});
      chk("R7 write blocked", {52'h0, res_ways[23:12]}, 64'h002);
      @(negedge clk);
    end
    @(posedge clk); #2;
    rsp_ready = 1'b1;
    wait_accept();
    m_w0[1] = 32'h0FF8_0003;
    @(negedge clk);
    chk("R7 write lands after release", {52'h0, res_ways[23:12]}, 64'h003);
    chk("R5 alloc after update", {52'h0, alloc_mask}, {52'h0, exp_alloc(1, active)});
    @(posedge clk); #2;
    rd(ad(1, 0), "R2 readback after stall");

    repeat (4) @(posedge clk);
    chk("R8 all responses seen", 64'(exp_q.size()), 64'h0);
    finish_run();
  end
endmodule